// File: doc/BRIEF.md
# Serial Audio Control Word Receiver

This block takes a fixed 36-bit control word from a three-wire serial link made of a bit clock, a data line and a framing enable. While the framing enable is high, each rising edge of the bit clock shifts one data bit into a shift register, with the first bit of the frame sent first. When the framing enable falls, a frame that held exactly 36 bits is copied into a pending settings register. A one-cycle strobe then tells the update scheduler that a new word is waiting.

The pending register is split into named control fields: input select, loudness, coarse and fine volume for each of two channels, level and boost/cut for three tone bands, fader level and fader front/rear select. The first two bits of a frame carry no setting. All three serial lines are asynchronous to the system clock. They pass through a chain of synchroniser flip-flops before any edge is detected. The block does not convert codes to gain, and it does not decide when the settings take effect.

Top module: `audio_ctl_rx`

## Requirements
- R1: A data bit is captured only on a rising edge of `ser_clk` while `ser_en` is high. Frame bits are numbered D1 (sent first) to D36 (sent last).
- R2: Once a frame is accepted, the fields follow these bit positions, with the lower-numbered bit as MSB:
  - `vol1_coarse` = D6..D9 and `vol1_fine` = D10..D12.
  - `vol2_coarse` = D13..D16 and `vol2_fine` = D17..D19.
  - `bass_lvl` = D20..D22 and `bass_boost` = D23.
  - `mid_lvl` = D24..D26 and `mid_boost` = D27.
  - `treb_lvl` = D28..D30 and `treb_boost` = D31.
  - `fade_lvl` = D32..D35 and `fade_front` = D36.
  - D1 and D2 change no output.
- R3: `in_sel` = {D3,D4}, where code 0 means the first input and code 3 the fourth. `loud_on` = D5.
- R4: After reset, the outputs take their default codes:
  - `in_sel` = 0 (first input) and `loud_on` = 0.
  - Both coarse volumes = 4'b0000 (mute) and both fine volumes = 3'b000 (-7 dB).
  - All tone levels = 3'b000 (0 dB) and all boost bits = 0.
  - `fade_lvl` = 4'b0000 (0 dB) and `fade_front` = 0 (rear).
  - `new_word` = 0.
- R5: `new_word` is high for exactly one system cycle per accepted frame.
- R6: The field outputs change only in the cycle in which `new_word` is high, and hold their value otherwise.
- R7: A frame with fewer than 36 bits is dropped. There is no `new_word`, and the fields keep their values.
- R8: A frame with more than 36 bits is dropped. There is no `new_word`, and the fields keep their values.
- R9: `ser_clk` edges while `ser_en` is low are not counted. A full 36-bit frame that follows such edges is still accepted.
- R10: `new_word` rises on the (SYNC_STAGES+2)th rising edge of `clk` after `ser_en` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_en | input | 1 | Frame enable, high during a transfer, idle high |
| new_word | output | 1 | One-cycle strobe: a new pending word is available |
| in_sel | output | 2 | Input select code |
| loud_on | output | 1 | Loudness enable |
| vol1_coarse | output | 4 | Channel 1 coarse volume code |
| vol1_fine | output | 3 | Channel 1 fine volume code |
| vol2_coarse | output | 4 | Channel 2 coarse volume code |
| vol2_fine | output | 3 | Channel 2 fine volume code |
| bass_lvl | output | 3 | Bass level code |
| bass_boost | output | 1 | Bass boost (1) or cut (0) |
| mid_lvl | output | 3 | Mid level code |
| mid_boost | output | 1 | Mid boost (1) or cut (0) |
| treb_lvl | output | 3 | Treble level code |
| treb_boost | output | 1 | Treble boost (1) or cut (0) |
| fade_lvl | output | 4 | Fader level code |
| fade_front | output | 1 | Fader target: front (1) or rear (0) |

## Verification
The bench builds the receiver with SYNC_STAGES set to 3 rather than the default 2. This makes the exact strobe latency of R10 depend on the parameter and not on a fixed constant. Frames of 35, 36 and 37 bits are sent, together with bit-clock edges during the idle-low phase of the enable, so the counting boundary is reached from both sides. Words that differ only in their two leading bits show that those bits have no effect.

// File: rtl/actl_pkg.sv
package actl_pkg;

    localparam int FRAME_BITS   = 36;
    localparam int LEAD_BITS    = 2;
    localparam int PAYLOAD_BITS = FRAME_BITS - LEAD_BITS;
    localparam int CNT_W        = $clog2(FRAME_BITS + 2);

    localparam int SEL_W    = 2;
    localparam int COARSE_W = 4;
    localparam int FINE_W   = 3;
    localparam int TONE_W   = 3;
    localparam int FADE_W   = 4;

    // Member order mirrors the frame from D3 down to D36 (MSB first).
    typedef struct packed {
        logic [SEL_W-1:0]    in_sel;
        logic                loud_on;
        logic [COARSE_W-1:0] vol1_coarse;
        logic [FINE_W-1:0]   vol1_fine;
        logic [COARSE_W-1:0] vol2_coarse;
        logic [FINE_W-1:0]   vol2_fine;
        logic [TONE_W-1:0]   bass_lvl;
        logic                bass_boost;
        logic [TONE_W-1:0]   mid_lvl;
        logic                mid_boost;
        logic [TONE_W-1:0]   treb_lvl;
        logic                treb_boost;
        logic [FADE_W-1:0]   fade_lvl;
        logic                fade_front;
    } ctl_fields_t;

    localparam logic [SEL_W-1:0]    SEL_FIRST   = 2'b00;
    localparam logic [COARSE_W-1:0] COARSE_MUTE = 4'b0000;
    localparam logic [FINE_W-1:0]   FINE_M7DB   = 3'b000;
    localparam logic [TONE_W-1:0]   TONE_FLAT   = 3'b000;
    localparam logic [FADE_W-1:0]   FADE_0DB    = 4'b0000;

    localparam ctl_fields_t FIELDS_RESET = '{
        in_sel:      SEL_FIRST,
        loud_on:     1'b0,
        vol1_coarse: COARSE_MUTE,
        vol1_fine:   FINE_M7DB,
        vol2_coarse: COARSE_MUTE,
        vol2_fine:   FINE_M7DB,
        bass_lvl:    TONE_FLAT,
        bass_boost:  1'b0,
        mid_lvl:     TONE_FLAT,
        mid_boost:   1'b0,
        treb_lvl:    TONE_FLAT,
        treb_boost:  1'b0,
        fade_lvl:    FADE_0DB,
        fade_front:  1'b0
    };

endpackage

// File: rtl/actl_sync.sv
module actl_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
        logic [W-1:0]             prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        st_d.prev = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pipe: {STAGES{RST_VAL}}, prev: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.pipe[STAGES-1];
    assign rise  = level & ~st_q.prev;
    assign fall  = ~level & st_q.prev;

endmodule

// File: rtl/actl_shift.sv
module actl_shift
    import actl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_in,
    input  logic                  bit_strobe,
    input  logic                  en_level,
    input  logic                  en_fall,
    output logic [FRAME_BITS-1:0] word,
    output logic                  done,
    output logic [CNT_W-1:0]      bit_cnt
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

    typedef struct packed {
        logic [FRAME_BITS-1:0] sr;
        logic [CNT_W-1:0]      cnt;
        logic                  done;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (en_fall) begin
            // End of frame: accept only an exact bit count, then rearm.
            st_d.done = (st_q.cnt == CNT_FULL);
            st_d.cnt  = '0;
        end else if (en_level && bit_strobe) begin
            st_d.sr = {st_q.sr[FRAME_BITS-2:0], bit_in};
            if (st_q.cnt != CNT_OVER) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sr: '0, cnt: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign word    = st_q.sr;
    assign done    = st_q.done;
    assign bit_cnt = st_q.cnt;

endmodule

// File: rtl/actl_decode.sv
module actl_decode
    import actl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FRAME_BITS-1:0] word,
    input  logic                  done,
    output ctl_fields_t           fields,
    output logic                  new_word
);

    typedef struct packed {
        ctl_fields_t f;
        logic        nw;
    } dec_st_t;

    dec_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.nw = done;
        if (done) begin
            // Leading no-op bits sit above the payload and are dropped here.
            st_d.f = ctl_fields_t'(word[PAYLOAD_BITS-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{f: FIELDS_RESET, nw: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fields   = st_q.f;
    assign new_word = st_q.nw;

endmodule

// File: rtl/audio_ctl_rx.sv
module audio_ctl_rx
    import actl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_clk,
    input  logic                ser_dat,
    input  logic                ser_en,
    output logic                new_word,
    output logic [SEL_W-1:0]    in_sel,
    output logic                loud_on,
    output logic [COARSE_W-1:0] vol1_coarse,
    output logic [FINE_W-1:0]   vol1_fine,
    output logic [COARSE_W-1:0] vol2_coarse,
    output logic [FINE_W-1:0]   vol2_fine,
    output logic [TONE_W-1:0]   bass_lvl,
    output logic                bass_boost,
    output logic [TONE_W-1:0]   mid_lvl,
    output logic                mid_boost,
    output logic [TONE_W-1:0]   treb_lvl,
    output logic                treb_boost,
    output logic [FADE_W-1:0]   fade_lvl,
    output logic                fade_front
);

    localparam int LINES = 3;
    localparam int IDX_DAT = 0;
    localparam int IDX_CLK = 1;
    localparam int IDX_EN  = 2;
    localparam logic [LINES-1:0] LINE_IDLE = 3'b100;

    logic [LINES-1:0]      line_lvl, line_rise, line_fall;
    logic [FRAME_BITS-1:0] shift_word;
    logic                  frame_done;
    logic [CNT_W-1:0]      bit_cnt;
    ctl_fields_t           fields;

    actl_sync #(
        .W       (LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LINE_IDLE)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_en, ser_clk, ser_dat}),
        .level    (line_lvl),
        .rise     (line_rise),
        .fall     (line_fall)
    );

    actl_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_in     (line_lvl[IDX_DAT]),
        .bit_strobe (line_rise[IDX_CLK]),
        .en_level   (line_lvl[IDX_EN]),
        .en_fall    (line_fall[IDX_EN]),
        .word       (shift_word),
        .done       (frame_done),
        .bit_cnt    (bit_cnt)
    );

    actl_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .word     (shift_word),
        .done     (frame_done),
        .fields   (fields),
        .new_word (new_word)
    );

    assign in_sel      = fields.in_sel;
    assign loud_on     = fields.loud_on;
    assign vol1_coarse = fields.vol1_coarse;
    assign vol1_fine   = fields.vol1_fine;
    assign vol2_coarse = fields.vol2_coarse;
    assign vol2_fine   = fields.vol2_fine;
    assign bass_lvl    = fields.bass_lvl;
    assign bass_boost  = fields.bass_boost;
    assign mid_lvl     = fields.mid_lvl;
    assign mid_boost   = fields.mid_boost;
    assign treb_lvl    = fields.treb_lvl;
    assign treb_boost  = fields.treb_boost;
    assign fade_lvl    = fields.fade_lvl;
    assign fade_front  = fields.fade_front;

    // Unused edge outputs of the synchroniser.
    logic unused_edges;
    assign unused_edges = ^{line_rise[IDX_DAT], line_rise[IDX_EN],
                            line_fall[IDX_DAT], line_fall[IDX_CLK]};

endmodule

// File: rtl/actl_check.sv
module actl_check
    import actl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             new_word,
    input ctl_fields_t      fields,
    input logic [CNT_W-1:0] bit_cnt
);

    // R5: strobe lasts one cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        new_word |=> !new_word);

    // R6: fields move only together with the strobe
    a_r6_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        !new_word |-> $stable(fields));

    // R4: defaults visible on the first cycle out of reset
    a_r4_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fields == FIELDS_RESET) && !new_word);

    // R7 / R8: a strobe follows only a frame of exactly FRAME_BITS bits
    a_r7_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        new_word |-> ($past(bit_cnt, 2) == CNT_W'(FRAME_BITS)));

endmodule

bind audio_ctl_rx actl_check u_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .new_word (new_word),
    .fields   (fields),
    .bit_cnt  (bit_cnt)
);

// File: tb/audio_ctl_rx_bench.sv
module audio_ctl_rx_bench;

    localparam time CLK_PERIOD = 10ns;
    localparam int  SYNC = 3;
    localparam int  HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b1;
    logic new_word;
    logic [1:0] in_sel;
    logic loud_on, bass_boost, mid_boost, treb_boost, fade_front;
    logic [3:0] vol1_coarse, vol2_coarse, fade_lvl;
    logic [2:0] vol1_fine, vol2_fine, bass_lvl, mid_lvl, treb_lvl;

    int checks = 0;
    int errors = 0;
    int nw_seen = 0;
    logic nw_prev = 1'b0;
    logic [35:0] exp_q[$];
    logic [35:0] last_w;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_ctl_rx #(.SYNC_STAGES(SYNC)) u_audio_ctl_rx (
        .clk, .rst_n, .ser_clk, .ser_dat, .ser_en, .new_word,
        .in_sel, .loud_on, .vol1_coarse, .vol1_fine, .vol2_coarse, .vol2_fine,
        .bass_lvl, .bass_boost, .mid_lvl, .mid_boost, .treb_lvl, .treb_boost,
        .fade_lvl, .fade_front
    );

    task automatic check(input string req, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Frame bit Dk lives at w[36-k].
    function automatic logic [3:0] fld(input logic [35:0] w, input int k, input int n);
        logic [3:0] r = '0;
        for (int i = 0; i < n; i++) r[n-1-i] = w[36-(k+i)];
        return r;
    endfunction

    task automatic compare_all(input logic [35:0] w, input string tag);
        check({tag, "/R3"}, "in_sel",  {2'b0, in_sel}, fld(w, 3, 2));
        check({tag, "/R3"}, "loud_on", {3'b0, loud_on}, fld(w, 5, 1));
        check({tag, "/R2"}, "vol1_coarse", vol1_coarse, fld(w, 6, 4));
        check({tag, "/R2"}, "vol1_fine", {1'b0, vol1_fine}, fld(w, 10, 3));
        check({tag, "/R2"}, "vol2_coarse", vol2_coarse, fld(w, 13, 4));
        check({tag, "/R2"}, "vol2_fine", {1'b0, vol2_fine}, fld(w, 17, 3));
        check({tag, "/R2"}, "bass_lvl", {1'b0, bass_lvl}, fld(w, 20, 3));
        check({tag, "/R2"}, "bass_boost", {3'b0, bass_boost}, fld(w, 23, 1));
        check({tag, "/R2"}, "mid_lvl", {1'b0, mid_lvl}, fld(w, 24, 3));
        check({tag, "/R2"}, "mid_boost", {3'b0, mid_boost}, fld(w, 27, 1));
        check({tag, "/R2"}, "treb_lvl", {1'b0, treb_lvl}, fld(w, 28, 3));
        check({tag, "/R2"}, "treb_boost", {3'b0, treb_boost}, fld(w, 31, 1));
        check({tag, "/R2"}, "fade_lvl", fade_lvl, fld(w, 32, 4));
        check({tag, "/R2"}, "fade_front", {3'b0, fade_front}, fld(w, 36, 1));
    endtask

    // Monitor: pops the scoreboard on every strobe.
    always @(negedge clk) begin
        if (rst_n && new_word) begin
            nw_seen++;
            checks++;
            if (nw_prev) begin
                errors++;
                $display("FAIL R5 strobe wider than one cycle actual=1 expected=0");
            end
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R7/R8 unexpected strobe actual=1 expected=0");
            end else begin
                last_w = exp_q.pop_front();
                compare_all(last_w, "R1");
            end
        end
        nw_prev = new_word;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: sends nbits of w (D1 first); accepted frames go to the scoreboard.
    task automatic send(input logic [35:0] w, input int nbits, input int junk);
        int start;
        int k;
        bit accept;
        accept = (nbits == 36);
        for (int i = 0; i < nbits; i++) begin
            wait_cyc(HALF);
            ser_dat = (i < 36) ? w[35-i] : 1'b1;
            wait_cyc(HALF);
            ser_clk = 1'b1;
            wait_cyc(HALF);
            ser_clk = 1'b0;
        end
        wait_cyc(HALF);
        if (accept) exp_q.push_back(w);
        start = nw_seen;
        ser_en = 1'b0;
        k = 0;
        while (k < SYNC + 8) begin
            @(negedge clk);
            k++;
            if (new_word) break;
        end
        if (accept) begin
            check("R10", "strobe latency", 4'(k), 4'(SYNC + 2));
        end else begin
            wait_cyc(10);
            check(nbits < 36 ? "R7" : "R8", "strobe count", 4'(nw_seen - start), 4'd0);
        end
        // Clock edges while the enable is low (R9).
        for (int j = 0; j < junk; j++) begin
            wait_cyc(HALF);
            ser_dat = j[0];
            ser_clk = 1'b1;
            wait_cyc(HALF);
            ser_clk = 1'b0;
        end
        wait_cyc(4 * HALF);
        ser_en = 1'b1;
        wait_cyc(4 * HALF);
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        // R4: defaults
        check("R4", "new_word", {3'b0, new_word}, 4'd0);
        compare_all(36'h0, "R4");
        last_w = 36'h0;

        send(36'hF_FFFF_FFFF, 36, 0);
        send(36'h3_5A5A_5A5A, 36, 0);
        send(36'h0_1234_5678, 36, 0);
        // R2: leading bits differ only; outputs must match
        send(36'hC_1234_5678, 36, 0);
        check("R2", "lead bits ignored in_sel", {2'b0, in_sel}, 4'd0);

        send(36'hA_AAAA_AAAA, 36, 0);
        // R7: short frame dropped, R6: fields hold
        send(36'h5_5555_5555, 35, 0);
        compare_all(36'hA_AAAA_AAAA, "R6");
        // R8: long frame dropped
        send(36'h5_5555_5555, 37, 0);
        compare_all(36'hA_AAAA_AAAA, "R6");
        // R9: edges while enable low do not count
        send(36'h2_4681_3579, 36, 3);
        send(36'h5_5555_5555, 36, 0);
        send(36'h0_0000_0000, 36, 0);
        compare_all(36'h0, "R2");

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R5 missing strobes actual=%0d expected=0", exp_q.size());
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule